// File: doc/BRIEF.md
# MDIO Management Master with Register Control

This block issues Clause 22 management frames toward Ethernet PHYs on a two-wire MDC/MDIO link, under the control of two memory-mapped registers. A host writes the target PHY address, the register number, a direction flag and a clock band code into the command register. Setting the start/busy flag in that same write launches the frame. For a write frame, the 16-bit payload must already be in the data register.

The block divides its system clock down to MDC, using a divider that the clock band code selects. It shifts the full frame out on MDIO and releases the line for the reply half of a read. It captures read data into the data register and drops busy by itself when the last bit is done. The host polls busy and then reads the data register. The MDIO pad is modelled as an output value, an output enable and an input.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, both registers read 0, MDC is low and the MDIO output enable is low.
- R2: The command register is at offset 0x10. Its fields are:
  - bit 0: busy/start
  - bit 1: 1 = write, 0 = read
  - bits 4:2: clock band code
  - bits 10:6: register number
  - bits 15:11: PHY address

  Bit 5 and bits 31:16 read 0. The data register is at offset 0x14 and holds 16 bits in bits 15:0. Any other offset reads 0.
- R3: A frame starts only when the command register is written with bit 0 set. A command write with bit 0 clear updates the fields and starts nothing.
- R4: One MDC period is a fixed number of system clocks, picked by the band code:

  | Code | Divider |
  |------|---------|
  | 0 | 42 |
  | 1 | 62 |
  | 2 | 16 |
  | 3 | 26 |
  | 4 | 102 |
  | 5, 6, 7 | 124 |

  A frame lasts 64 MDC periods, so busy stays high for exactly 64 x divider system clocks.
- R5: A write frame is 64 bits, sent MSB first, all driven by the master:
  - 32 ones
  - 0, 1
  - opcode 0, 1
  - 5 bits of PHY address
  - 5 bits of register number
  - 1, 0
  - the 16 data bits
- R6: A read frame drives the first 46 bits, using opcode 1, 0. The master releases MDIO from bit 46 (turnaround) through bit 63. It samples bits 48 to 63 at MDC rising edges, MSB first, into the data register.
- R7: Busy clears by itself at the end of the frame. While busy is low, MDC is low and MDIO is released.
- R8: A command register write while busy is set has no effect on the stored fields and starts no further frame.
- R9: A data register write while busy is set has no effect.
- R10: The master changes the MDIO output only on the system clock edge where MDC falls, so every bit is stable around the MDC rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The following are checked on every cycle:
- MDC and the output enable are idle whenever busy is low.
- The MDIO output moves only on MDC falling edges.
- The command fields and the write payload hold still during a frame.
- A read never re-drives the line once it has released it.
- A start-less command write does not raise busy.
- Busy lasts exactly 64 divider periods for the band code in use.

The bench scenarios show the rest:
- the exact bit sequence of each frame, as seen by a PHY model;
- the read payload arriving in the data register;
- the absence of any frame after an ignored command write;
- the divider for every band code, including the two fallback codes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam logic [5:0] TA_IDX   = 6'd46;
  localparam logic [5:0] DATA_IDX = 6'd48;
  localparam logic [5:0] LAST_IDX = 6'd63;

  // System clocks per MDC period for each band code
  function automatic int unsigned mdc_div(input logic [2:0] code);
    case (code)
      3'd0:    mdc_div = 42;
      3'd1:    mdc_div = 62;
      3'd2:    mdc_div = 16;
      3'd3:    mdc_div = 26;
      3'd4:    mdc_div = 102;
      default: mdc_div = 124;
    endcase
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] code,
  output logic       mdc,
  output logic       rise_tick,
  output logic       fall_tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d, half_m1;
  logic             mdc_q, mdc_d, tick;

  assign half_m1   = CNT_W'(mdc_div(code) >> 1) - CNT_W'(1);
  assign tick      = run && (cnt_q == half_m1);
  assign rise_tick = tick && !mdc_q;
  assign fall_tick = tick && mdc_q;
  assign mdc       = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_read,
  input  logic [AW-1:0] phy,
  input  logic [AW-1:0] regn,
  input  logic [DW-1:0] wdata,
  input  logic          rise_tick,
  input  logic          fall_tick,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic          sample_en,
  output logic          done
);
  logic [FRAME_LEN-1:0] sreg_q, sreg_d;
  logic [5:0]           idx_q, idx_d;
  logic                 act_q, act_d, rd_q, rd_d;

  assign done      = act_q && fall_tick && (idx_q == LAST_IDX);
  assign sample_en = act_q && rise_tick && rd_q && (idx_q >= DATA_IDX);
  assign mdio_oe   = act_q && !(rd_q && (idx_q >= TA_IDX));
  assign mdio_o    = act_q && sreg_q[FRAME_LEN-1];

  always_comb begin
    sreg_d = sreg_q;
    idx_d  = idx_q;
    act_d  = act_q;
    rd_d   = rd_q;
    if (start) begin
      sreg_d = {32'hFFFF_FFFF, 2'b01, (is_read ? 2'b10 : 2'b01), phy, regn,
                (is_read ? 2'b11 : 2'b10), (is_read ? {DW{1'b0}} : wdata)};
      idx_d  = '0;
      act_d  = 1'b1;
      rd_d   = is_read;
    end else if (act_q && fall_tick) begin
      if (idx_q == LAST_IDX) begin
        act_d = 1'b0;
      end else begin
        idx_d  = idx_q + 6'd1;
        sreg_d = {sreg_q[FRAME_LEN-2:0], 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      idx_q  <= '0;
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      idx_q  <= idx_d;
      act_q  <= act_d;
      rd_q   <= rd_d;
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int          BUS_AW   = 8,
  parameter int          BUS_DW   = 32,
  parameter logic [7:0]  CMD_OFF  = 8'h10,
  parameter logic [7:0]  DATA_OFF = 8'h14,
  parameter int          CNT_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int AW = 5;
  localparam int DW = 16;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic          busy_q, busy_d, wr_q, wr_d;
  logic [2:0]    code_q, code_d;
  logic [AW-1:0] reg_q, reg_d, phy_q, phy_d;
  logic [DW-1:0] data_q, data_d;
  logic          cmd_we, data_we, start;
  logic          rise_tick, fall_tick, sample_en, done;

  assign cmd_we  = bus_wr && (bus_addr == BUS_AW'(CMD_OFF))  && !busy_q;
  assign data_we = bus_wr && (bus_addr == BUS_AW'(DATA_OFF)) && !busy_q;
  assign start   = cmd_we && bus_wdata[0];

  always_comb begin
    busy_d = busy_q;
    wr_d   = wr_q;
    code_d = code_q;
    reg_d  = reg_q;
    phy_d  = phy_q;
    data_d = data_q;
    if (cmd_we) begin
      wr_d   = bus_wdata[1];
      code_d = bus_wdata[4:2];
      reg_d  = bus_wdata[10:6];
      phy_d  = bus_wdata[15:11];
      busy_d = bus_wdata[0];
    end else if (done) begin
      busy_d = 1'b0;
    end
    if (data_we)        data_d = bus_wdata[DW-1:0];
    else if (sample_en) data_d = {data_q[DW-2:0], mdio_i};
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      code_q <= '0;
      reg_q  <= '0;
      phy_q  <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      wr_q   <= wr_d;
      code_q <= code_d;
      reg_q  <= reg_d;
      phy_q  <= phy_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == BUS_AW'(CMD_OFF))
      bus_rdata[15:0] = {phy_q, reg_q, 1'b0, code_q, wr_q, busy_q};
    else if (bus_addr == BUS_AW'(DATA_OFF))
      bus_rdata[DW-1:0] = data_q;
  end

  mdio_clkgen #(.CNT_W(CNT_W)) u_clkgen (
    .clk(clk), .rst_n(rst_int_n), .run(busy_q), .code(code_q),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .start(start), .is_read(!bus_wdata[1]),
    .phy(bus_wdata[15:11]), .regn(bus_wdata[10:6]), .wdata(data_q),
    .rise_tick(rise_tick), .fall_tick(fall_tick),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .sample_en(sample_en), .done(done)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk
  import mdio_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        busy_q,
  input logic        wr_q,
  input logic [2:0]  code_q,
  input logic [14:0] fields,
  input logic [15:0] data_q,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  logic [15:0] len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (busy_q) len_q <= len_q + 16'd1;
    else             len_q <= '0;
  end

  p_idle_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc && !mdio_oe));

  p_drive_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$stable(mdio_o)) |-> $fell(mdc));

  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(fields));

  p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && wr_q) |-> $stable(data_q));

  p_rd_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !wr_q && !$past(mdio_oe)) |-> !mdio_oe);

  p_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h10 && !bus_wdata[0] && !busy_q) |=> !busy_q);

  p_frame_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (32'(len_q) == 32'(FRAME_LEN) * mdc_div(code_q)));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .busy_q(busy_q), .wr_q(wr_q), .code_q(code_q),
  .fields({phy_q, reg_q, code_q, wr_q, 1'b0}), .data_q(data_q),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/tb_mdio_mgmt_master.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_master;
  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, mdio_i = 1'b1;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  int          checks = 0, errors = 0;
  int          pos = 0;
  logic [63:0] cap_bits = '0, cap_oe = '0;
  logic [15:0] rd_word = '0;

  always #4 clk = ~clk;

  mdio_mgmt_master dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: record each bit at MDC rise, present reply bits after MDC fall
  always @(posedge mdc) begin
    if (pos < 64) begin
      cap_bits[63-pos] = mdio_o;
      cap_oe[63-pos]   = mdio_oe;
    end
    pos = pos + 1;
  end
  always @(negedge mdc) begin
    if (pos >= 48 && pos <= 63) mdio_i = rd_word[63-pos];
    else                        mdio_i = 1'b1;
  end

  function automatic int exp_div(input logic [2:0] code);
    case (code)
      3'd0: return 42;  3'd1: return 62;  3'd2: return 16;
      3'd3: return 26;  3'd4: return 102; default: return 124;
    endcase
  endfunction

  function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
            (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0)};
  endfunction

  function automatic logic [63:0] exp_oe(input logic wr);
    return wr ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, 18'h0};
  endfunction

  function automatic logic [31:0] cmd_word(input logic [4:0] phy, input logic [4:0] rg,
                                           input logic [2:0] code, input logic wr,
                                           input logic go);
    return {16'h0, phy, rg, 1'b0, code, wr, go};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // tasks enter just after a falling clock edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_wr = 1'b0;
    #1 d = bus_rdata;
    @(negedge clk);
  endtask

  task automatic xfer(input logic wr, input logic [2:0] code, input logic [4:0] phy,
                      input logic [4:0] rg, input logic [15:0] d, input logic [15:0] reply,
                      input bit inject);
    int cnt;
    logic [31:0] v;
    logic [63:0] ef, eo;
    bit masked_ok;
    if (wr) bus_write(8'h14, {16'h0, d});
    rd_word = reply;
    pos = 0;
    bus_write(8'h10, cmd_word(phy, rg, code, wr, 1'b1));
    cnt = 0;
    forever begin
      if (inject && cnt == 100) begin
        bus_addr = 8'h10; bus_wdata = cmd_word(~phy, ~rg, ~code, ~wr, 1'b1); bus_wr = 1'b1;
      end else if (inject && cnt == 101) begin
        bus_addr = 8'h14; bus_wdata = {16'h0, ~d}; bus_wr = 1'b1;
      end else begin
        bus_addr = 8'h10; bus_wr = 1'b0;
      end
      #1;
      if (bus_addr == 8'h10 && !bus_rdata[0]) break;
      cnt++;
      @(negedge clk);
    end
    bus_wr = 1'b0;
    check(cnt == 64 * exp_div(code), "R4 busy length", 64'(cnt), 64'(64 * exp_div(code)));
    check(pos == 64, "R7 mdc rising edges per frame", 64'(pos), 64'd64);
    ef = exp_frame(wr, phy, rg, d);
    eo = exp_oe(wr);
    check(cap_oe == eo, wr ? "R5 output enable pattern" : "R6 release from turnaround",
          cap_oe, eo);
    masked_ok = ((cap_bits & eo) == (ef & eo));
    check(masked_ok, wr ? "R5 write frame bits" : "R6 read frame header bits",
          cap_bits & eo, ef & eo);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R7 lines idle after frame",
          {mdc, mdio_oe}, 2'b00);
    @(negedge clk);
    bus_read(8'h10, v);
    check(v == cmd_word(phy, rg, code, wr, 1'b0),
          inject ? "R8 command fields kept" : "R7 busy cleared", v, cmd_word(phy, rg, code, wr, 1'b0));
    bus_read(8'h14, v);
    check(v == {16'h0, wr ? d : reply},
          wr ? (inject ? "R9 data write ignored" : "R5 data kept") : "R6 read data",
          v, {16'h0, wr ? d : reply});
    if (inject) begin
      repeat (300) @(negedge clk);
      check(pos == 64, "R8 no second frame", 64'(pos), 64'd64);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(8'h10, v); check(v == 32'h0, "R1 command reset", v, 0);
    bus_read(8'h14, v); check(v == 32'h0, "R1 data reset", v, 0);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle lines", {mdc, mdio_oe}, 0);

    // R2 layout and R3 no start without bit 0
    pos = 0;
    bus_write(8'h10, 32'hFFFF_FFFE);
    bus_read(8'h10, v); check(v == 32'h0000_FFDE, "R2 command readback", v, 32'h0000_FFDE);
    bus_write(8'h14, 32'hABCD_1234);
    bus_read(8'h14, v); check(v == 32'h0000_1234, "R2 data readback", v, 32'h0000_1234);
    bus_read(8'h18, v); check(v == 32'h0, "R2 unmapped offset", v, 0);
    repeat (300) @(negedge clk);
    check(pos == 0 && mdc == 1'b0, "R3 no frame without start", 64'(pos), 0);
    bus_read(8'h10, v); check(v[0] == 1'b0, "R3 busy stays low", 64'(v[0]), 0);

    // directed frames over every band code
    xfer(1'b1, 3'd2, 5'h1F, 5'h00, 16'hA55A, 16'h0, 1'b0);
    xfer(1'b0, 3'd2, 5'h00, 5'h1F, 16'h0, 16'h8001, 1'b0);
    xfer(1'b1, 3'd0, 5'h0A, 5'h15, 16'hFFFF, 16'h0, 1'b0);
    xfer(1'b0, 3'd1, 5'h15, 5'h0A, 16'h0, 16'h0000, 1'b0);
    xfer(1'b0, 3'd3, 5'h03, 5'h11, 16'h0, 16'hFFFF, 1'b0);
    xfer(1'b1, 3'd4, 5'h11, 5'h03, 16'h0000, 16'h0, 1'b0);
    xfer(1'b0, 3'd5, 5'h07, 5'h02, 16'h0, 16'h3C5A, 1'b0);
    xfer(1'b1, 3'd6, 5'h1C, 5'h1E, 16'h1357, 16'h0, 1'b0);
    xfer(1'b0, 3'd7, 5'h01, 5'h01, 16'h0, 16'hC3A5, 1'b0);

    // R8, R9: writes during busy ignored
    xfer(1'b1, 3'd2, 5'h05, 5'h06, 16'h6789, 16'h0, 1'b1);
    xfer(1'b0, 3'd3, 5'h09, 5'h0C, 16'h0, 16'h2468, 1'b1);

    // random frames on the short dividers
    for (int i = 0; i < 14; i++) begin
      logic        w;
      logic [2:0]  c;
      w = 1'($urandom);
      c = ($urandom % 2 == 0) ? 3'd2 : 3'd3;
      xfer(w, c, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
           ($urandom % 4 == 0));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule